// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner

This block sits between the raw clock and data pads of a two-wire serial target and the protocol logic behind it. Both lines are sampled with the system clock and pass through a two-stage synchronizer. Each line then goes through a pulse-width filter that accepts a new level only after it has held for a set number of cycles. From the two clean levels the block derives single-cycle strobes for start conditions, stop conditions and clock edges. It also reports whether the bus is idle.

On the transmit side, the protocol logic states the data level it wants on the line. The block updates its open-drain pull-down only after the filtered clock has stayed low for a set hold time. It never updates it while the clock is high. The data value this device puts on the bus therefore cannot change near a clock edge, and transmitting cannot create a false start or stop condition.

Top module: `twi_line_cond`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scl_level`, `sda_level` and `bus_idle` read 1, and all strobes and `sda_drive_low` read 0.
- R2: A level change on either raw input appears on its filtered output exactly FILT_CYC+2 rising clock edges after the first edge that samples the new value.
- R3: An excursion on either raw input that lasts fewer than FILT_CYC sampled cycles is discarded. It changes no filtered level and raises no strobe. An excursion of FILT_CYC cycles or more is accepted.
- R4: When filtered SDA goes from 1 to 0 while filtered SCL stays 1, `start_pulse` is high for exactly one cycle, one edge after the filtered change.
- R5: When filtered SDA goes from 0 to 1 while filtered SCL stays 1, `stop_pulse` is high for exactly one cycle, one edge after the filtered change.
- R6: `scl_rise` and `scl_fall` each pulse for exactly one cycle, one edge after the filtered SCL level rises or falls. `start_pulse` and `stop_pulse` are never high together, and neither are `scl_rise` and `scl_fall`.
- R7: SDA changes while filtered SCL is 0 raise neither `start_pulse` nor `stop_pulse`.
- R8: `sda_drive_low` never changes while filtered SCL is 1. After filtered SCL falls, it takes the value of `tx_drive_low` no earlier than HOLD_CYC+1 edges later. Once SCL has been low for that long, it follows `tx_drive_low` one edge after a change.
- R9: `bus_idle` is 1 after reset and after a stop while both filtered lines are 1. It is 0 from the cycle `start_pulse` is high until a stop.
- R10: The data pad is open drain. `sda_drive_low` = 1 pulls the line low, and `sda_drive_low` = 0 releases it so that it reads high unless another device pulls it low. The device's own drive is therefore seen on `sda_level` after the R2 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pad | input | 1 | Raw serial clock line |
| sda_pad | input | 1 | Raw serial data line |
| tx_drive_low | input | 1 | Requested data pull-down from the protocol logic |
| scl_level | output | 1 | Filtered clock level |
| sda_level | output | 1 | Filtered data level |
| start_pulse | output | 1 | One-cycle start condition strobe |
| stop_pulse | output | 1 | One-cycle stop condition strobe |
| scl_rise | output | 1 | One-cycle filtered clock rising strobe |
| scl_fall | output | 1 | One-cycle filtered clock falling strobe |
| bus_idle | output | 1 | Bus free: both lines high with no open transfer |
| sda_drive_low | output | 1 | Open-drain pull-down enable for the data pad |

## Verification
On every cycle, the assertions check the following: filtered levels move only after a full filter count, strobes are mutually exclusive, a start always clears the idle flag, and the pull-down stays fixed while the clock is high. Only the bench scenarios can show the exact latencies and the accept or reject boundary of the filter, found by sweeping excursion widths across it. The same holds for the hold-time count after a clock fall, and for the way the device's own drive shows up on the filtered data level.

// File: rtl/twi_lc_pkg.sv
package twi_lc_pkg;

    // Event strobes derived from the clean line levels
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } twi_evt_t;

    localparam twi_evt_t TWI_EVT_NONE = '{start: 1'b0, stop: 1'b0, rise: 1'b0, fall: 1'b0};

    // Lane indices into the packed raw/filtered line vectors
    localparam int unsigned LANE_SCL = 0;
    localparam int unsigned LANE_SDA = 1;
    localparam int unsigned N_LANES  = 2;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: {STAGES{RST_VAL}}};
        else        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int unsigned FILT_CYC = 5,
    parameter logic        RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.lvl = din;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: RST_VAL, cnt: '0};
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;

    AST_FILT_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> ($past(st_q.cnt) == CNT_LAST)); // R3

    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> (st_q.lvl == $past(din))); // R2
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_lc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output twi_evt_t evt,
    output logic     idle
);
    typedef struct packed {
        logic     scl_p;
        logic     sda_p;
        logic     busy;
        logic     idle;
        twi_evt_t evt;
    } cd_st_t;

    cd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.scl_p     = scl_f;
        st_d.sda_p     = sda_f;
        st_d.evt       = TWI_EVT_NONE;
        st_d.evt.start = st_q.scl_p & scl_f & st_q.sda_p & ~sda_f;
        st_d.evt.stop  = st_q.scl_p & scl_f & ~st_q.sda_p & sda_f;
        st_d.evt.rise  = ~st_q.scl_p & scl_f;
        st_d.evt.fall  = st_q.scl_p & ~scl_f;
        if (st_d.evt.start)     st_d.busy = 1'b1;
        else if (st_d.evt.stop) st_d.busy = 1'b0;
        st_d.idle = ~st_d.busy & scl_f & sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0, idle: 1'b1, evt: TWI_EVT_NONE};
        else        st_q <= st_d;
    end

    assign evt  = st_q.evt;
    assign idle = st_q.idle;

    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.evt.start, st_q.evt.stop})); // R6

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.evt.rise, st_q.evt.fall})); // R6

    AST_START_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt.start |-> !st_q.idle); // R9

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt.start |=> !st_q.evt.start); // R4

    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt.stop |=> !st_q.evt.stop); // R5
endmodule

// File: rtl/twi_hold_delay.sv
module twi_hold_delay #(
    parameter int unsigned HOLD_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic req_low,
    output logic drive_low
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(HOLD_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          drv;
    } hd_st_t;

    hd_st_t st_d, st_q;
    logic   allow;

    always_comb begin
        st_d  = st_q;
        allow = ~scl_f & (st_q.cnt == CNT_MAX);
        if (scl_f)                  st_d.cnt = '0;
        else if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        if (allow) st_d.drv = req_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, drv: 1'b0};
        else        st_q <= st_d;
    end

    assign drive_low = st_q.drv;

    AST_DRV_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        scl_f |=> $stable(st_q.drv)); // R8

    AST_DRV_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.drv) |-> ($past(st_q.cnt) == CNT_MAX)); // R8
endmodule

// File: rtl/twi_line_cond.sv
module twi_line_cond
    import twi_lc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYC    = 5,
    parameter int unsigned HOLD_CYC    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pad,
    input  logic sda_pad,
    input  logic tx_drive_low,
    output logic scl_level,
    output logic sda_level,
    output logic start_pulse,
    output logic stop_pulse,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_idle,
    output logic sda_drive_low
);
    logic [N_LANES-1:0] raw_v, sync_v, filt_v;
    twi_evt_t           evt;

    assign raw_v[LANE_SCL] = scl_pad;
    assign raw_v[LANE_SDA] = sda_pad;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        twi_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_v[g]),
            .dout (sync_v[g])
        );

        twi_glitch_filter #(
            .FILT_CYC(FILT_CYC),
            .RST_VAL (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_v[g]),
            .level(filt_v[g])
        );
    end

    twi_cond_detect u_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(filt_v[LANE_SCL]),
        .sda_f(filt_v[LANE_SDA]),
        .evt  (evt),
        .idle (bus_idle)
    );

    twi_hold_delay #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_v[LANE_SCL]),
        .req_low  (tx_drive_low),
        .drive_low(sda_drive_low)
    );

    assign scl_level   = filt_v[LANE_SCL];
    assign sda_level   = filt_v[LANE_SDA];
    assign start_pulse = evt.start;
    assign stop_pulse  = evt.stop;
    assign scl_rise    = evt.rise;
    assign scl_fall    = evt.fall;

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_level) |=> scl_rise); // R6

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_level) |=> scl_fall); // R6

    AST_NO_COND_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_level && $past(!scl_level)) |=> !(start_pulse || stop_pulse)); // R7
endmodule

// File: tb/twi_line_cond_test.sv
module twi_line_cond_test;
    localparam int F = 5;
    localparam int H = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic tx_req = 1'b0;
    logic sda_line;
    logic scl_level, sda_level, start_pulse, stop_pulse, scl_rise, scl_fall, bus_idle, sda_drive_low;

    int n_chk = 0;
    int n_fail = 0;
    int c_start = 0, c_stop = 0, c_rise = 0, c_fall = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // open-drain pad: master release or device pull-down
    assign sda_line = sda_m & ~sda_drive_low;

    twi_line_cond #(.FILT_CYC(F), .HOLD_CYC(H)) uut (
        .clk(clk), .rst_n(rst_n), .scl_pad(scl_m), .sda_pad(sda_line),
        .tx_drive_low(tx_req), .scl_level(scl_level), .sda_level(sda_level),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_idle(bus_idle), .sda_drive_low(sda_drive_low)
    );

    always @(negedge clk) if (rst_n) begin
        c_start += int'(start_pulse);
        c_stop  += int'(stop_pulse);
        c_rise  += int'(scl_rise);
        c_fall  += int'(scl_fall);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int s0, p0, r0, f0, n, acc;
        cyc(3);
        // R1 reset state during reset
        chk("R1 scl_level", int'(scl_level), 1);
        chk("R1 sda_level", int'(sda_level), 1);
        chk("R1 strobes", int'({start_pulse, stop_pulse, scl_rise, scl_fall}), 0);
        chk("R1 drive", int'(sda_drive_low), 0);
        chk("R1 idle", int'(bus_idle), 1);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after release", int'({scl_level, sda_level, bus_idle, sda_drive_low}), 4'b1110);
        cyc(10);

        // R3 sweep of data excursions while clock high (R4/R5 when accepted)
        for (int w = 1; w <= F + 2; w++) begin
            acc = (w >= F) ? 1 : 0;
            s0 = c_start; p0 = c_stop;
            sda_m = 1'b0; cyc(w); sda_m = 1'b1; cyc(3 * F + 10);
            chk($sformatf("R3/R4 start w=%0d", w), c_start - s0, acc);
            chk($sformatf("R3/R5 stop w=%0d", w), c_stop - p0, acc);
            chk($sformatf("R9 idle w=%0d", w), int'(bus_idle), 1);
        end

        // R3 sweep of clock excursions while data high
        for (int w = 1; w <= F + 2; w++) begin
            acc = (w >= F) ? 1 : 0;
            s0 = c_start; p0 = c_stop; r0 = c_rise; f0 = c_fall;
            scl_m = 1'b0; cyc(w); scl_m = 1'b1; cyc(3 * F + 10);
            chk($sformatf("R3/R6 fall w=%0d", w), c_fall - f0, acc);
            chk($sformatf("R3/R6 rise w=%0d", w), c_rise - r0, acc);
            chk($sformatf("R3 no cond w=%0d", w), (c_start - s0) + (c_stop - p0), 0);
        end

        // R2 latency and R6 single strobe on a clock fall
        f0 = c_fall;
        scl_m = 1'b0;
        n = 0;
        for (int k = 1; k <= 4 * F; k++) begin
            cyc(1);
            if (n == 0 && scl_level == 1'b0) n = k;
        end
        chk("R2 scl latency", n, F + 2);
        chk("R6 single fall", c_fall - f0, 1);

        // R7 data toggles while clock low
        s0 = c_start; p0 = c_stop;
        sda_m = 1'b0; cyc(2 * F + 6);
        chk("R7 sda follows low", int'(sda_level), 0);
        sda_m = 1'b1; cyc(2 * F + 6);
        chk("R7 sda follows high", int'(sda_level), 1);
        chk("R7 no cond", (c_start - s0) + (c_stop - p0), 0);
        scl_m = 1'b1; cyc(2 * F + 6);

        // R9 start then stop
        sda_m = 1'b0; cyc(2 * F + 6);
        chk("R9 busy after start", int'(bus_idle), 0);
        scl_m = 1'b0; cyc(2 * F + 6);
        sda_m = 1'b1; cyc(2 * F + 6);
        scl_m = 1'b1; cyc(2 * F + 6);
        chk("R9 still busy", int'(bus_idle), 0);

        // R8 request during clock high is held off
        tx_req = 1'b1; cyc(20);
        chk("R8 no drive scl high", int'(sda_drive_low), 0);
        s0 = c_start; p0 = c_stop;
        scl_m = 1'b0;
        n = 0;
        for (int k = 1; k <= F + H + 20; k++) begin
            cyc(1);
            if (n == 0 && sda_drive_low == 1'b1) n = k;
        end
        chk("R8 hold delay", n, F + H + 3);
        // R10 own pull-down seen on filtered level
        chk("R10 line pulled low", int'(sda_level), 0);
        tx_req = 1'b0; cyc(1);
        chk("R8 follow when settled", int'(sda_drive_low), 0);
        cyc(F + 4);
        chk("R10 release reads high", int'(sda_level), 1);
        chk("R7 no cond while driving", (c_start - s0) + (c_stop - p0), 0);

        // R5/R9 stop frees the bus
        sda_m = 1'b0; cyc(2 * F + 6);
        scl_m = 1'b1; cyc(2 * F + 6);
        p0 = c_stop;
        sda_m = 1'b1; cyc(2 * F + 6);
        chk("R5 stop seen", c_stop - p0, 1);
        chk("R9 idle after stop", int'(bus_idle), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule